// File: doc/BRIEF.md
# Per-Frame Alpha Fade and Color-Key Unit

This unit governs a single alpha-blending window in a video overlay path. It keeps an 8-bit alpha level that can fade up or down without software help: at each frame start a signed 8-bit step is added to it. When a step reaches full scale (255) or zero, the level is clamped there. It then stays frozen at that value until software reloads it. A reload is requested by writing a new level together with a load flag. The new level replaces the running one at the next frame start, and that frame skips its step.

For every pixel the unit also chooses what the pixel carries:
- **pass-through**: the pixel is outside the window, or the window is inactive.
- **blend**: the pixel uses the alpha-blended graphics/video result.
- **key color**: a fixed 24-bit substitute color replaces the pixel.

The key color replaces the blend only where the pixel matches the color key, the substitution is enabled, and the window is active. The window is active when its own enable and the global video-window enable are both set. The blend arithmetic is done downstream. This unit supplies the current alpha and the per-pixel select.

Top module: `alpha_fade_key`

## Requirements
- R1: After synchronous reset, `alpha_cur` is 0, every control field is 0, and `pix_sel` is 2'b00 (pass) with `pix_color` 0.
- R2: On a `frame_start` cycle with no pending load and no frozen level, `alpha_cur` takes the value of itself plus the two's-complement `cfg_incr`, visible the cycle after.
- R3: A step that would go below 0 or above 255 yields exactly 0 or 255. Once a step yields 0 or 255, later frame starts leave `alpha_cur` unchanged, whatever the increment, until a reload is applied.
- R4: With `cfg_incr` zero, `alpha_cur` stays constant across frame starts.
- R5: A write with `cfg_load` set does not change `alpha_cur`. At the next `frame_start`, `alpha_cur` becomes the written level, and no step is applied on that frame.
- R6: Applying a reload clears the pending request. Later frame starts step from the loaded level.
- R7: When a write with `cfg_load` falls in the same cycle as `frame_start`, that frame uses the state from before the write. The new level is applied at the following frame start.
- R8: When the window enable, `video_en` or `pix_in_win` is 0, `pix_sel` is 2'b00 (pass) and `pix_color` is 0.
- R9: In an active window with `pix_in_win` set and the key substitution disabled, `pix_sel` is 2'b01 (blend), with or without a key match.
- R10: In an active window with `pix_in_win`, a key match and key substitution enabled, `pix_sel` is 2'b10 (key) and `pix_color` equals the written key color. Without a match, `pix_sel` is 2'b01.
- R11: `alpha_cur` changes only in the cycle after a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for all control fields |
| cfg_alpha | input | 8 | Alpha level staged for reload |
| cfg_incr | input | 8 | Signed per-frame step |
| cfg_load | input | 1 | Request reload at next frame start (write only) |
| cfg_win_en | input | 1 | Window enable |
| cfg_key_en | input | 1 | Key color substitution enable |
| cfg_key_color | input | 24 | Substitute color |
| frame_start | input | 1 | One-cycle frame start pulse |
| video_en | input | 1 | Global video window enable |
| pix_in_win | input | 1 | Pixel lies inside the window |
| pix_key_match | input | 1 | Pixel matches the color key |
| alpha_cur | output | 8 | Alpha level in use for this frame |
| pix_sel | output | 2 | 00 pass, 01 blend, 10 key color |
| pix_color | output | 24 | Substitute color when `pix_sel` is 10, else 0 |

## Verification
The reload path and the frame step can land in the same cycle. This happens when a write carrying the load flag coincides with a frame-start pulse. The bench provokes this twice:
- once while an earlier reload is still pending, where the old staged level must win;
- once with nothing pending, where an ordinary step must happen.

In both cases the freshly written level must appear exactly one frame later, and the bench compares `alpha_cur` against hand-computed values after each frame.

// File: rtl/afk_pkg.sv
package afk_pkg;

    typedef enum logic [1:0] {
        SEL_PASS  = 2'b00,
        SEL_BLEND = 2'b01,
        SEL_KEY   = 2'b10
    } afk_sel_e;

    typedef struct packed {
        logic in_win;
        logic key_match;
    } afk_pix_t;

    function automatic logic win_active(input logic own_en, input logic global_en);
        return own_en & global_en;
    endfunction

endpackage

// File: rtl/afk_cfg_regs.sv
module afk_cfg_regs #(
    parameter int ALPHA_W = 8,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ALPHA_W-1:0] wr_alpha,
    input  logic [ALPHA_W-1:0] wr_incr,
    input  logic               wr_load,
    input  logic               wr_win_en,
    input  logic               wr_key_en,
    input  logic [COLOR_W-1:0] wr_key_color,
    input  logic               frame_start,
    output logic [ALPHA_W-1:0] staged_alpha,
    output logic [ALPHA_W-1:0] incr_q,
    output logic               win_en_q,
    output logic               key_en_q,
    output logic [COLOR_W-1:0] key_color_q,
    output logic               load_pend,
    output logic               load_apply
);

    // A frame start consumes whatever was pending before this cycle.
    assign load_apply = frame_start & load_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_alpha <= '0;
            incr_q       <= '0;
            win_en_q     <= 1'b0;
            key_en_q     <= 1'b0;
            key_color_q  <= '0;
            load_pend    <= 1'b0;
        end else begin
            if (we) begin
                staged_alpha <= wr_alpha;
                incr_q       <= wr_incr;
                win_en_q     <= wr_win_en;
                key_en_q     <= wr_key_en;
                key_color_q  <= wr_key_color;
            end
            // A fresh request survives a coincident frame start.
            if (we && wr_load) begin
                load_pend <= 1'b1;
            end else if (frame_start) begin
                load_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/afk_alpha_step.sv
module afk_alpha_step #(
    parameter int ALPHA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               load_apply,
    input  logic [ALPHA_W-1:0] staged_alpha,
    input  logic [ALPHA_W-1:0] incr,
    output logic [ALPHA_W-1:0] alpha_q,
    output logic               hold_q
);

    localparam int                 SUM_W = ALPHA_W + 2;
    localparam logic [ALPHA_W-1:0] A_MAX = '1;
    localparam logic [ALPHA_W-1:0] A_MIN = '0;

    logic signed [SUM_W-1:0] sum;
    logic        [ALPHA_W-1:0] stepped;
    logic                      at_rail;

    always_comb begin
        sum = $signed({2'b00, alpha_q}) + $signed({{2{incr[ALPHA_W-1]}}, incr});
        if (sum < 0) begin
            stepped = A_MIN;
        end else if (sum > $signed({2'b00, A_MAX})) begin
            stepped = A_MAX;
        end else begin
            stepped = sum[ALPHA_W-1:0];
        end
        at_rail = (stepped == A_MIN) || (stepped == A_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q <= '0;
            hold_q  <= 1'b0;
        end else if (load_apply) begin
            alpha_q <= staged_alpha;
            hold_q  <= 1'b0;
        end else if (frame_start && !hold_q) begin
            alpha_q <= stepped;
            hold_q  <= at_rail;
        end
    end

endmodule

// File: rtl/afk_pix_sel.sv
module afk_pix_sel
    import afk_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  logic               win_on,
    input  afk_pix_t           pix,
    input  logic               key_en,
    input  logic [COLOR_W-1:0] key_color,
    output afk_sel_e           sel,
    output logic [COLOR_W-1:0] color
);

    always_comb begin
        sel   = SEL_PASS;
        color = '0;
        if (win_on && pix.in_win) begin
            if (key_en && pix.key_match) begin
                sel   = SEL_KEY;
                color = key_color;
            end else begin
                sel = SEL_BLEND;
            end
        end
    end

endmodule

// File: rtl/alpha_fade_key.sv
module alpha_fade_key
    import afk_pkg::*;
#(
    parameter int ALPHA_W = 8,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ALPHA_W-1:0] cfg_alpha,
    input  logic [ALPHA_W-1:0] cfg_incr,
    input  logic               cfg_load,
    input  logic               cfg_win_en,
    input  logic               cfg_key_en,
    input  logic [COLOR_W-1:0] cfg_key_color,
    input  logic               frame_start,
    input  logic               video_en,
    input  logic               pix_in_win,
    input  logic               pix_key_match,
    output logic [ALPHA_W-1:0] alpha_cur,
    output logic [1:0]         pix_sel,
    output logic [COLOR_W-1:0] pix_color
);

    logic [ALPHA_W-1:0] staged_alpha;
    logic [ALPHA_W-1:0] incr_q;
    logic               win_en_q;
    logic               key_en_q;
    logic [COLOR_W-1:0] key_color_q;
    logic               load_pend;
    logic               load_apply;
    logic               hold_q;
    logic               win_on;
    afk_pix_t           pix;
    afk_sel_e           sel;

    afk_cfg_regs #(.ALPHA_W(ALPHA_W), .COLOR_W(COLOR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .we           (cfg_we),
        .wr_alpha     (cfg_alpha),
        .wr_incr      (cfg_incr),
        .wr_load      (cfg_load),
        .wr_win_en    (cfg_win_en),
        .wr_key_en    (cfg_key_en),
        .wr_key_color (cfg_key_color),
        .frame_start  (frame_start),
        .staged_alpha (staged_alpha),
        .incr_q       (incr_q),
        .win_en_q     (win_en_q),
        .key_en_q     (key_en_q),
        .key_color_q  (key_color_q),
        .load_pend    (load_pend),
        .load_apply   (load_apply)
    );

    afk_alpha_step #(.ALPHA_W(ALPHA_W)) u_step (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .load_apply   (load_apply),
        .staged_alpha (staged_alpha),
        .incr         (incr_q),
        .alpha_q      (alpha_cur),
        .hold_q       (hold_q)
    );

    assign win_on = win_active(win_en_q, video_en);
    assign pix    = '{in_win: pix_in_win, key_match: pix_key_match};

    afk_pix_sel #(.COLOR_W(COLOR_W)) u_sel (
        .win_on    (win_on),
        .pix       (pix),
        .key_en    (key_en_q),
        .key_color (key_color_q),
        .sel       (sel),
        .color     (pix_color)
    );

    assign pix_sel = sel;

endmodule

// File: rtl/afk_chk.sv
module afk_chk #(
    parameter int ALPHA_W = 8,
    parameter int COLOR_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_start,
    input logic [ALPHA_W-1:0] alpha_cur,
    input logic [1:0]         pix_sel,
    input logic [COLOR_W-1:0] pix_color,
    input logic               pix_in_win,
    input logic               pix_key_match,
    input logic               win_on,
    input logic               key_en_q,
    input logic [COLOR_W-1:0] key_color_q,
    input logic               load_pend,
    input logic [ALPHA_W-1:0] staged_alpha,
    input logic               hold_q
);

    // R1
    reset_state_chk: assert property (@(posedge clk) $past(rst) |-> (alpha_cur == '0));

    // R11
    alpha_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(alpha_cur));

    // R3
    rail_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && hold_q && !load_pend) |=> $stable(alpha_cur));

    // R5
    load_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && load_pend) |=> (alpha_cur == $past(staged_alpha)));

    // R8
    no_override_chk: assert property (@(posedge clk) disable iff (rst)
        !(win_on && pix_in_win) |-> (pix_sel == 2'b00 && pix_color == '0));

    // R9
    blend_only_chk: assert property (@(posedge clk) disable iff (rst)
        (win_on && pix_in_win && !key_en_q) |-> (pix_sel == 2'b01));

    // R10
    key_color_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_sel == 2'b10) |-> (pix_key_match && pix_color == key_color_q));

endmodule

bind alpha_fade_key afk_chk #(.ALPHA_W(ALPHA_W), .COLOR_W(COLOR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .alpha_cur     (alpha_cur),
    .pix_sel       (pix_sel),
    .pix_color     (pix_color),
    .pix_in_win    (pix_in_win),
    .pix_key_match (pix_key_match),
    .win_on        (win_on),
    .key_en_q      (key_en_q),
    .key_color_q   (key_color_q),
    .load_pend     (load_pend),
    .staged_alpha  (staged_alpha),
    .hold_q        (hold_q)
);

// File: tb/alpha_fade_key_bench.sv
module alpha_fade_key_bench;

    localparam int CLK_P  = 10;
    localparam int N_VEC  = 8;
    localparam logic [23:0] KCOL = 24'hA1B2C3;

    // {win_en, video_en, key_en, in_win, match, exp_sel[1:0]}
    localparam logic [6:0] VEC [N_VEC] = '{
        7'b11111_10,
        7'b11011_01,
        7'b11110_01,
        7'b11101_00,
        7'b01111_00,
        7'b10111_00,
        7'b11000_00,
        7'b11010_01
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_alpha = '0;
    logic [7:0]  cfg_incr = '0;
    logic        cfg_load = 1'b0;
    logic        cfg_win_en = 1'b0;
    logic        cfg_key_en = 1'b0;
    logic [23:0] cfg_key_color = '0;
    logic        frame_start = 1'b0;
    logic        video_en = 1'b0;
    logic        pix_in_win = 1'b0;
    logic        pix_key_match = 1'b0;
    logic [7:0]  alpha_cur;
    logic [1:0]  pix_sel;
    logic [23:0] pix_color;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    alpha_fade_key u_alpha_fade_key (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_alpha     (cfg_alpha),
        .cfg_incr      (cfg_incr),
        .cfg_load      (cfg_load),
        .cfg_win_en    (cfg_win_en),
        .cfg_key_en    (cfg_key_en),
        .cfg_key_color (cfg_key_color),
        .frame_start   (frame_start),
        .video_en      (video_en),
        .pix_in_win    (pix_in_win),
        .pix_key_match (pix_key_match),
        .alpha_cur     (alpha_cur),
        .pix_sel       (pix_sel),
        .pix_color     (pix_color)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] inc, input logic ld,
                      input logic wen, input logic ken, input logic fs);
        @(negedge clk);
        cfg_we = 1'b1; cfg_alpha = a; cfg_incr = inc; cfg_load = ld;
        cfg_win_en = wen; cfg_key_en = ken; cfg_key_color = KCOL;
        frame_start = fs;
        @(negedge clk);
        cfg_we = 1'b0; cfg_load = 1'b0; frame_start = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic frame_chk(input string req, input logic [7:0] exp);
        frame();
        check(req, {24'd0, alpha_cur}, {24'd0, exp});
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 alpha", {24'd0, alpha_cur}, 32'd0);
        pix_in_win = 1'b1; pix_key_match = 1'b1; video_en = 1'b1; #1;
        check("R1 sel", {30'd0, pix_sel}, 32'd0);
        check("R1 color", {8'd0, pix_color}, 32'd0);

        // Pixel selection table (R8 R9 R10)
        for (int i = 0; i < N_VEC; i++) begin
            wr(8'd0, 8'd0, 1'b0, VEC[i][6], VEC[i][4], 1'b0);
            video_en = VEC[i][5]; pix_in_win = VEC[i][3]; pix_key_match = VEC[i][2];
            #1;
            check("R8_R9_R10 sel", {30'd0, pix_sel}, {30'd0, VEC[i][1:0]});
            check("R8_R10 color", {8'd0, pix_color},
                  (VEC[i][1:0] == 2'b10) ? {8'd0, KCOL} : 32'd0);
        end

        // R5 load deferred, then applied without step
        wr(8'd100, 8'd20, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 not immediate", {24'd0, alpha_cur}, 32'd0);
        frame_chk("R5 applied", 8'd100);
        frame_chk("R6 step after load", 8'd120);
        frame_chk("R2 up", 8'd140);
        wr(8'd0, 8'hCE, 1'b0, 1'b1, 1'b0, 1'b0);
        frame_chk("R2 down", 8'd90);
        frame_chk("R2 down", 8'd40);
        frame_chk("R3 low clamp", 8'd0);
        wr(8'd0, 8'd30, 1'b0, 1'b1, 1'b0, 1'b0);
        frame_chk("R3 low hold", 8'd0);

        wr(8'd250, 8'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        frame_chk("R5 reload", 8'd250);
        frame_chk("R2 up", 8'd253);
        frame_chk("R3 high clamp", 8'd255);
        wr(8'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
        frame_chk("R3 high hold", 8'd255);

        wr(8'd77, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        frame_chk("R5 reload", 8'd77);
        frame_chk("R4 zero incr", 8'd77);
        frame_chk("R4 zero incr", 8'd77);
        repeat (3) @(negedge clk);
        check("R11 idle stable", {24'd0, alpha_cur}, 32'd77);

        // R7 coincidence with an older reload pending
        wr(8'd10, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        wr(8'd200, 8'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R7 old staged wins", {24'd0, alpha_cur}, 32'd10);
        frame_chk("R7 new applied next", 8'd200);

        // R7 coincidence with nothing pending: ordinary step
        wr(8'd0, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
        wr(8'd50, 8'd5, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R7 step on coincident frame", {24'd0, alpha_cur}, 32'd205);
        frame_chk("R7 reload next frame", 8'd50);
        frame_chk("R6 step from loaded", 8'd55);

        // R1 again: reset clears fields
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        video_en = 1'b1; pix_in_win = 1'b1; #1;
        check("R1 reset alpha", {24'd0, alpha_cur}, 32'd0);
        check("R1 reset win_en", {30'd0, pix_sel}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule